// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block turns parallel 24-bit audio samples into serial bit streams on up to four data lines. Each line carries two channels per frame, or, in time-division mode, line zero carries every channel of the frame in turn. Four framings are available: I2S, left-justified, right-justified with an offset that depends on the word length, and a TDM variant marked by a one-bit frame pulse.

As clock master the block divides its system clock down to a bit clock and produces the frame clock itself. As clock slave it follows a bit clock and a frame clock that arrive from outside. It samples them with the system clock and re-aligns its frame on every frame-start edge. All outputs change only after a falling bit-clock edge.

One complete set of channel words is offered per frame over a valid/ready handshake. It is held until the next frame boundary. If no set has arrived by then, the previous samples are sent again and a one-cycle underrun pulse is raised.

Top module: `aud_ser_tx`

## Requirements
- R1: In master mode `bclk_out` stays high for `cfg_bclk_div`+1 system clock cycles and then low for `cfg_bclk_div`+1 cycles. Its period is therefore 2·(`cfg_bclk_div`+1) cycles.
- R2: In master mode `sdata_out` and `lrclk_out` change only in the cycle in which `bclk_out` falls. A receiver that samples on the rising bit-clock edge therefore sees settled values.
- R3: `cfg_fmt` selects the framing: 0 is I2S, 1 is left-justified, 2 is right-justified and 3 is TDM. A stereo frame has 64 bit clocks made of two 32-bit slots. Line L carries channel 2L in slot 0 and channel 2L+1 in slot 1. In I2S the frame clock is low for slot 0 and the MSB comes one bit clock after the frame-clock edge. In left-justified mode the frame clock is high for slot 0 and the MSB coincides with the edge.
- R4: In right-justified mode the MSB is placed so that the word ends on the last bit of its slot. It starts 8, 12, 14 or 16 bit clocks into the slot for 24-, 20-, 18- or 16-bit words.
- R5: `cfg_wlen` 0, 1, 2 and 3 select 24-, 20-, 18- and 16-bit words. The MSB-first word is taken from the top bits of the 24-bit sample. Every slot bit that carries no word bit is driven low.
- R6: In TDM mode a frame has 32·2·4 = 256 bit clocks. Line 0 carries channel s in slot s, left-aligned. The other lines stay low. The frame clock is high during the first bit clock of the frame only.
- R7: `s_data` holds channel c in bits [24c+23:24c]. `s_ready` is high while the holding register is empty. A word set is taken when `s_valid` and `s_ready` are both high, `s_ready` then drops, and the set is sent from the next frame start onward.
- R8: If no word set is waiting at a frame start, the previous samples are sent again. `underrun` is then high for one cycle, in the cycle in which the frame starts on the lines.
- R9: In slave mode all data lines stay low until the first frame-start edge of `lrclk_in` has been seen. A word set that is accepted earlier is first sent in the frame that this edge starts.
- R10: In slave mode the frame position follows `lrclk_in`, sampled at falling edges of `bclk_in`. The start edge is falling for I2S and rising for the other formats. Data shifts after each falling `bclk_in`, and `bclk_out` and `lrclk_out` stay low.
- R11: While `rst` is high, `sdata_out`, `bclk_out`, `lrclk_out` and `underrun` are low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate the bit and frame clocks, 0: follow external clocks |
| cfg_fmt | input | 2 | Framing select (0 I2S, 1 left-justified, 2 right-justified, 3 TDM) |
| cfg_wlen | input | 2 | Word length select (0:24, 1:20, 2:18, 3:16 bits) |
| cfg_bclk_div | input | 8 | Half bit-clock period minus one, in system clock cycles |
| s_valid | input | 1 | Word set offered |
| s_ready | output | 1 | Holding register empty |
| s_data | input | 192 | Eight 24-bit channel samples |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| lrclk_out | output | 1 | Generated frame clock (master mode) |
| sdata_out | output | 4 | Serial data lines |
| underrun | output | 1 | One-cycle pulse: frame started without a new word set |

## Verification
The assertions assume that the configuration inputs change only while reset is held, because a format change in mid-frame would break the stability and line-usage properties. They also assume that, in slave mode, each half period of the external bit clock lasts several system clock cycles, and that the external frame clock changes together with the falling bit clock. The bench reapplies reset before every configuration and drives its slave clocks with eight-cycle half periods. It moves the frame clock only on its own falling bit-clock edges, and it offers word sets only in the middle of a frame, so a handshake never meets a frame boundary.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SLOT_W   = 32;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_TDM = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WL_24 = 2'd0,
        WL_20 = 2'd1,
        WL_18 = 2'd2,
        WL_16 = 2'd3
    } wlen_e;

    // Timing events handed from the clock stage to the serializer.
    typedef struct packed {
        logic tick;    // a falling bit-clock instant happens now
        logic fstart;  // slave: this instant begins a frame
    } bit_evt_t;

    function automatic logic [5:0] word_bits(wlen_e w);
        case (w)
            WL_24:   return 6'd24;
            WL_20:   return 6'd20;
            WL_18:   return 6'd18;
            default: return 6'd16;
        endcase
    endfunction

    // Slot position that carries the MSB.
    function automatic logic [5:0] msb_pos(fmt_e f, wlen_e w);
        case (f)
            FMT_I2S: return 6'd1;
            FMT_RJ:  return 6'd32 - word_bits(w);
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic slot_bit(fmt_e f, wlen_e w, logic [4:0] pos,
                                      logic [SAMPLE_W-1:0] word);
        logic [5:0] pos6;
        logic [5:0] off;
        logic [5:0] k;
        pos6 = {1'b0, pos};
        off  = msb_pos(f, w);
        if (pos6 < off) return 1'b0;
        k = pos6 - off;
        if (k >= word_bits(w)) return 1'b0;
        return word[5'(SAMPLE_W - 1) - k[4:0]];
    endfunction

    function automatic logic frame_level(fmt_e f, logic first_bit, logic right_slot);
        case (f)
            FMT_I2S: return right_slot;
            FMT_TDM: return first_bit;
            default: return ~right_slot;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_clk.sv
module aud_tx_clk
    import aud_tx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master,
    input  fmt_e             fmt,
    input  logic [DIV_W-1:0] div,
    input  logic             bclk_in,
    input  logic             lrclk_in,
    output logic             bclk_out,
    output bit_evt_t         evt
);
    logic [DIV_W-1:0] cnt;
    logic             bclk_q;
    logic [2:0]       b_sync;
    logic [1:0]       l_sync;
    logic             lr_last;
    logic             primed;
    logic             tick_m, tick_s, start_lvl;

    always_ff @(posedge clk) begin
        if (rst || !master) begin
            cnt    <= '0;
            bclk_q <= 1'b0;
        end else if (cnt == div) begin
            cnt    <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_sync  <= '0;
            l_sync  <= '0;
            lr_last <= 1'b0;
            primed  <= 1'b0;
        end else begin
            b_sync <= {b_sync[1:0], bclk_in};
            l_sync <= {l_sync[0], lrclk_in};
            if (tick_s) begin
                lr_last <= l_sync[1];
                primed  <= 1'b1;
            end
        end
    end

    assign tick_m     = master && (cnt == div) && bclk_q;
    assign tick_s     = !master && b_sync[2] && !b_sync[1];
    assign start_lvl  = (fmt != FMT_I2S);
    assign evt.tick   = tick_m || tick_s;
    assign evt.fstart = tick_s && primed && (l_sync[1] != lr_last) && (l_sync[1] == start_lvl);
    assign bclk_out   = bclk_q;

    p_fall_after_tick_r1: assert property (@(posedge clk) disable iff (rst)
        (master && evt.tick) |=> !bclk_out)
        else $error("bit clock did not fall after a master tick");

    p_fall_needs_tick_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(bclk_out) |-> $past(evt.tick))
        else $error("bit clock fell without a tick");

    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !master |=> !bclk_out)
        else $error("bit clock driven in slave mode");

endmodule

// File: rtl/aud_tx_buf.sv
module aud_tx_buf
    import aud_tx_pkg::*;
#(
    parameter int CH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [CH*SAMPLE_W-1:0] s_data,
    input  logic                load,
    output logic [SAMPLE_W-1:0] cur_nx [CH],
    output logic                underrun
);
    logic [SAMPLE_W-1:0] pend [CH];
    logic [SAMPLE_W-1:0] cur  [CH];
    logic                pend_full;
    logic                accept;

    assign s_ready = !pend_full;
    assign accept  = s_valid && !pend_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_full <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            underrun <= load && !pend_full;
            if (load && pend_full) pend_full <= 1'b0;
            else if (accept)       pend_full <= 1'b1;
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[c] <= '0;
                cur[c]  <= '0;
            end else begin
                if (accept && !load) pend[c] <= s_data[c*SAMPLE_W +: SAMPLE_W];
                else if (accept && load) pend[c] <= s_data[c*SAMPLE_W +: SAMPLE_W];
                if (load && pend_full) cur[c] <= pend[c];
            end
        end
        assign cur_nx[c] = (load && pend_full) ? pend[c] : cur[c];
    end

    p_hold_full_r7: assert property (@(posedge clk) disable iff (rst)
        (!s_ready && !load) |=> !s_ready)
        else $error("holding register emptied without a frame start");

    p_underrun_empty_r8: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $past(s_ready))
        else $error("underrun flagged while a word set was waiting");

    p_cur_steady_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cur[0]))
        else $error("live sample changed outside a frame start");

endmodule

// File: rtl/aud_tx_ser.sv
module aud_tx_ser
    import aud_tx_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int CH        = 2 * NUM_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 master,
    input  fmt_e                 fmt,
    input  wlen_e                wlen,
    input  bit_evt_t             evt,
    input  logic [SAMPLE_W-1:0]  cur_nx [CH],
    output logic                 load,
    output logic [NUM_LINES-1:0] sdata_out,
    output logic                 lrclk_out
);
    localparam int FRAME_TDM = SLOT_W * CH;
    localparam int PW        = $clog2(FRAME_TDM);
    localparam int SIW       = PW - 5;

    logic [PW-1:0]        pos, pos_nx, frame_last;
    logic [SIW-1:0]       slot;
    logic                 started, go;
    logic [NUM_LINES-1:0] line_bit;

    assign frame_last = (fmt == FMT_TDM) ? PW'(FRAME_TDM - 1) : PW'(2 * SLOT_W - 1);

    always_comb begin
        if (!master && evt.fstart)  pos_nx = '0;
        else if (pos == frame_last) pos_nx = '0;
        else                        pos_nx = pos + 1'b1;
    end

    assign slot = pos_nx[PW-1:5];
    assign load = evt.tick && (master ? (pos == frame_last) : evt.fstart);
    assign go   = master || started || evt.fstart;

    for (genvar L = 0; L < NUM_LINES; L++) begin : g_line
        logic [SIW-1:0] ch;
        logic           on;
        always_comb begin
            if (fmt == FMT_TDM) begin
                ch = slot;
                on = (L == 0);
            end else begin
                ch = SIW'(2 * L) + SIW'(slot[0]);
                on = 1'b1;
            end
            line_bit[L] = on && slot_bit(fmt, wlen, pos_nx[4:0], cur_nx[ch]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= frame_last;
            started   <= 1'b0;
            sdata_out <= '0;
            lrclk_out <= 1'b0;
        end else if (evt.tick) begin
            pos <= pos_nx;
            if (evt.fstart) started <= 1'b1;
            sdata_out <= go ? line_bit : '0;
            lrclk_out <= master && frame_level(fmt, pos_nx == '0, slot[0]);
        end
    end

    p_data_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(sdata_out))
        else $error("data changed away from a falling bit clock");

    p_frame_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(lrclk_out))
        else $error("frame clock changed away from a falling bit clock");

    p_wait_first_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (!master && !started && !evt.fstart) |=> (sdata_out == '0))
        else $error("slave drove data before the first frame edge");

    p_tdm_lines_r6: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_TDM) |-> ((sdata_out >> 1) == '0))
        else $error("TDM drove a line other than line zero");

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DIV_W     = 8,
    localparam int CH       = 2 * NUM_LINES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_master,
    input  logic [1:0]              cfg_fmt,
    input  logic [1:0]              cfg_wlen,
    input  logic [DIV_W-1:0]        cfg_bclk_div,
    input  logic                    s_valid,
    output logic                    s_ready,
    input  logic [CH*SAMPLE_W-1:0]  s_data,
    input  logic                    bclk_in,
    input  logic                    lrclk_in,
    output logic                    bclk_out,
    output logic                    lrclk_out,
    output logic [NUM_LINES-1:0]    sdata_out,
    output logic                    underrun
);
    fmt_e                fmt;
    wlen_e               wlen;
    bit_evt_t            evt;
    logic                load;
    logic [SAMPLE_W-1:0] cur_nx [CH];

    assign fmt  = fmt_e'(cfg_fmt);
    assign wlen = wlen_e'(cfg_wlen);

    aud_tx_clk #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .master(cfg_master), .fmt(fmt), .div(cfg_bclk_div),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in), .bclk_out(bclk_out), .evt(evt)
    );

    aud_tx_buf #(.CH(CH)) u_buf (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .load(load), .cur_nx(cur_nx), .underrun(underrun)
    );

    aud_tx_ser #(.NUM_LINES(NUM_LINES), .CH(CH)) u_ser (
        .clk(clk), .rst(rst), .master(cfg_master), .fmt(fmt), .wlen(wlen), .evt(evt),
        .cur_nx(cur_nx), .load(load), .sdata_out(sdata_out), .lrclk_out(lrclk_out)
    );

endmodule

// File: tb/aud_ser_tx_bench.sv
module aud_ser_tx_bench;
    localparam int NL = 4;
    localparam int CH = 8;
    localparam int SW = 24;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          cfg_master = 1'b1;
    logic [1:0]    cfg_fmt = 2'd0, cfg_wlen = 2'd0;
    logic [7:0]    cfg_bclk_div = 8'd3;
    logic          s_valid = 1'b0, s_ready;
    logic [CH*SW-1:0] s_data = '0;
    logic          bclk_drv = 1'b0, lrclk_drv = 1'b0;
    logic          bclk_out, lrclk_out, underrun;
    logic [NL-1:0] sdata_out;

    aud_ser_tx u_aud_ser_tx (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
        .cfg_wlen(cfg_wlen), .cfg_bclk_div(cfg_bclk_div), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .bclk_in(bclk_drv), .lrclk_in(lrclk_drv),
        .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sdata_out(sdata_out),
        .underrun(underrun)
    );

    int checks = 0, errors = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference knowledge from the requirements ----------------
    function automatic int flen(logic [1:0] f);
        return (f == 2'd3) ? 256 : 64;
    endfunction
    function automatic int wbits(logic [1:0] w);
        case (w) 2'd0: return 24; 2'd1: return 20; 2'd2: return 18; default: return 16; endcase
    endfunction
    function automatic int moff(logic [1:0] f, logic [1:0] w);
        if (f == 2'd0) return 1;
        if (f == 2'd2) return 32 - wbits(w);
        return 0;
    endfunction
    function automatic bit exp_lr(logic [1:0] f, int p);
        if (f == 2'd0) return p >= 32;
        if (f == 2'd3) return p == 0;
        return p < 32;
    endfunction

    // ---------------- bench state ----------------
    logic [SW-1:0] exp_cur [CH];
    logic [SW-1:0] pend_w  [CH];
    bit            pend_flag, have_frame, saw_ur, mon_en, drv_on, lr_en;
    int            frames, pos, hcnt, dpos, cyc, last_fall;
    int            per_err, per_n, stab_err, wait_err, wait_n;
    logic          prev_b, prev_lr;
    logic [NL-1:0] prev_sd;
    logic [NL-1:0] cap_d [256];
    logic          cap_l [256];

    task automatic decode_frame();
        int fl, bad, lrbad, fp, fl_line;
        logic ea, eb;
        string tag;
        fl = flen(cfg_fmt); bad = 0; lrbad = 0; fp = -1; fl_line = 0; ea = 0; eb = 0;
        for (int p = 0; p < fl; p++) begin
            for (int l = 0; l < NL; l++) begin
                int ch, k;
                logic e;
                if (cfg_fmt == 2'd3) ch = (l == 0) ? p / 32 : -1;
                else                 ch = 2 * l + p / 32;
                k = (p % 32) - moff(cfg_fmt, cfg_wlen);
                e = (ch >= 0 && k >= 0 && k < wbits(cfg_wlen)) ? exp_cur[ch][SW-1-k] : 1'b0;
                if (cap_d[p][l] !== e) begin
                    bad++;
                    if (fp < 0) begin fp = p; fl_line = l; ea = cap_d[p][l]; eb = e; end
                end
            end
            if (cap_l[p] !== exp_lr(cfg_fmt, p)) lrbad++;
        end
        if (!cfg_master)          tag = "R10 R5";
        else if (cfg_fmt == 2'd2) tag = "R4 R5";
        else if (cfg_fmt == 2'd3) tag = "R6 R5";
        else                      tag = "R3 R5";
        chk(bad == 0, tag, $sformatf("frame %0d bit mismatches, first at pos %0d line %0d",
            frames, fp, fl_line), longint'(ea), longint'(eb));
        if (cfg_master)
            chk(lrbad == 0, "R3", "frame clock phase mismatches", lrbad, 0);
    endtask

    task automatic slave_drive();
        int fl;
        fl = flen(cfg_fmt);
        hcnt++;
        if (hcnt == 8) begin
            hcnt = 0;
            bclk_drv = ~bclk_drv;
            if (!bclk_drv) begin
                if (lr_en) begin
                    dpos = (dpos == fl - 1) ? 0 : dpos + 1;
                    lrclk_drv = exp_lr(cfg_fmt, dpos);
                end else begin
                    lrclk_drv = exp_lr(cfg_fmt, 0);
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            logic ob, lr;
            bit st;
            ob = cfg_master ? bclk_out : bclk_drv;
            lr = cfg_master ? lrclk_out : lrclk_drv;
            cyc++;
            if (cfg_master) begin
                if (prev_b && !ob) begin
                    if (last_fall >= 0) begin
                        per_n++;
                        if (cyc - last_fall != 2 * (int'(cfg_bclk_div) + 1)) per_err++;
                    end
                    last_fall = cyc;
                end else if (sdata_out !== prev_sd) begin
                    stab_err++;
                end
            end else if (frames == 0) begin
                wait_n++;
                if (sdata_out !== '0) wait_err++;
            end
            if (underrun) saw_ur = 1;
            if (!prev_b && ob) begin
                st = (cfg_fmt == 2'd0) ? (prev_lr && !lr) : (!prev_lr && lr);
                if (st) begin
                    if (have_frame) begin
                        chk(pos == flen(cfg_fmt) - 1, "R3", "bit clocks per frame",
                            pos + 1, flen(cfg_fmt));
                        decode_frame();
                    end
                    chk(saw_ur == !pend_flag, "R8", "underrun at frame start",
                        saw_ur, !pend_flag);
                    saw_ur = 0;
                    if (pend_flag) begin
                        exp_cur = pend_w;
                        pend_flag = 0;
                    end
                    pos = 0;
                    have_frame = 1;
                    frames++;
                end else begin
                    pos++;
                end
                if (pos >= 0 && pos < 256) begin
                    cap_d[pos] = sdata_out;
                    cap_l[pos] = lr;
                end
                prev_lr = lr;
            end
            prev_b = ob;
            prev_sd = sdata_out;
            if (drv_on) slave_drive();
        end
    end

    task automatic push();
        logic [SW-1:0] w [CH];
        for (int c = 0; c < CH; c++) w[c] = SW'($urandom);
        @(negedge clk);
        chk(s_ready == 1'b1, "R7", "ready before offer", s_ready, 1);
        s_valid = 1'b1;
        for (int c = 0; c < CH; c++) s_data[c*SW +: SW] = w[c];
        @(negedge clk);
        s_valid = 1'b0;
        chk(s_ready == 1'b0, "R7", "ready after accept", s_ready, 0);
        @(posedge clk); #1;
        pend_w = w;
        pend_flag = 1;
    endtask

    task automatic run_mode(bit m, logic [1:0] f, logic [1:0] w, logic [7:0] d,
                            int nfr, int skip);
        @(posedge clk); #1;
        mon_en = 0; drv_on = 0; lr_en = 0;
        rst = 1; cfg_master = m; cfg_fmt = f; cfg_wlen = w; cfg_bclk_div = d;
        bclk_drv = 0; lrclk_drv = m ? 1'b0 : exp_lr(f, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(sdata_out == '0, "R11", "data in reset", sdata_out, 0);
        chk(s_ready == 1'b1, "R11", "ready in reset", s_ready, 1);
        chk(underrun == 1'b0 && bclk_out == 1'b0 && lrclk_out == 1'b0, "R11",
            "clocks and flag in reset", {underrun, bclk_out, lrclk_out}, 0);
        for (int c = 0; c < CH; c++) exp_cur[c] = '0;
        pend_flag = 0; have_frame = 0; saw_ur = 0; frames = 0; pos = -1000;
        hcnt = 0; dpos = flen(f) - 1; cyc = 0; last_fall = -1;
        per_err = 0; per_n = 0; stab_err = 0; wait_err = 0; wait_n = 0;
        prev_b = 0; prev_lr = m ? 1'b0 : exp_lr(f, 0); prev_sd = '0;
        @(posedge clk); #1;
        rst = 0; mon_en = 1; drv_on = !m;
        if (!m) begin
            push();
            repeat (200) @(posedge clk);
            #1 lr_en = 1;
        end
        for (int i = 1; i <= nfr; i++) begin
            wait (frames >= i);
            if (i != skip) push();
        end
        wait (frames >= nfr + 1);
        if (m) begin
            chk(per_n > 0 && per_err == 0, "R1", "bit clock period errors", per_err, 0);
            chk(stab_err == 0, "R2", "output changes off a falling edge", stab_err, 0);
        end else begin
            chk(wait_n > 0 && wait_err == 0, "R9", "data before first frame edge",
                wait_err, 0);
            chk(bclk_out == 1'b0 && lrclk_out == 1'b0, "R10", "clock outputs in slave",
                {bclk_out, lrclk_out}, 0);
        end
    endtask

    initial begin
        mon_en = 0; drv_on = 0; lr_en = 0;
        run_mode(1, 2'd0, 2'd0, 8'd3, 4, 2);   // I2S 24-bit, one underrun frame
        run_mode(1, 2'd1, 2'd1, 8'd1, 3, 0);   // left-justified 20-bit
        run_mode(1, 2'd2, 2'd0, 8'd3, 2, 0);   // right-justified 24
        run_mode(1, 2'd2, 2'd1, 8'd2, 2, 0);   // right-justified 20
        run_mode(1, 2'd2, 2'd2, 8'd2, 2, 0);   // right-justified 18
        run_mode(1, 2'd2, 2'd3, 8'd2, 3, 2);   // right-justified 16, underrun
        run_mode(1, 2'd3, 2'd0, 8'd2, 3, 1);   // TDM 24, underrun
        run_mode(0, 2'd0, 2'd0, 8'd0, 3, 0);   // slave I2S
        run_mode(0, 2'd2, 2'd3, 8'd0, 3, 2);   // slave right-justified 16
        run_mode(0, 2'd3, 2'd2, 8'd0, 2, 0);   // slave TDM 18
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=%0d expected=%0d", frames, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule